// File: doc/BRIEF.md
# Tagged Geometric-History Value Predictor

This block guesses the 64-bit result of an instruction before it executes. The guess is based on two inputs: the instruction address and a 64-bit global branch history. A tagless last-value table, indexed by the address, gives the fallback guess. Six partially tagged tables sit beside it. Tagged table i hashes the address with the newest 2^i history bits, so the six tables see 2, 4, 8, 16, 32 and 64 bits. All tables are read in parallel. The hitting table with the longest history supplies the value.

A request presents an address and a history. One cycle later the block returns a value, the number of the table that supplied it (the provider) and a use flag. The use flag is set only when the provider's 3-bit confidence counter is saturated.

After the real result is known, the pipeline sends back a training request. It carries the same address and history, the real result and the provider number it was given. The block then updates the provider's counter and value, allocates a longer-history entry when the guess was wrong, and keeps track of which entries are useful. Table sizes, tag width and the period at which usefulness is cleared are parameters.

Top module: `geo_value_predictor`

## Requirements
- R1: After reset every request returns value 0, use flag 0 and provider 0. pred_valid is high in exactly the cycle after a cycle with pred_req high, and low otherwise.
- R2: When no tagged table hits, the provider is 0 and the value comes from the base table. The base table is indexed by the address alone.
- R3: When several tagged tables hit, the provider is the highest-numbered hitting table, and its value is returned.
- R4: Tagged table i (1 to 6) depends only on history bits [2^i-1:0], where bit 0 is the newest. Flipping history bit b moves the entry of every table with 2^i > b and of no other table.
- R5: pred_use is 1 exactly when the provider's counter equals 7. Each correct training of the provider increments its counter, saturating at 7.
- R6: A wrong training (stored value differs from the result) sets the provider's counter to 0 and replaces its stored value with the result.
- R7: A wrong training allocates an entry in the lowest-numbered table above the provider whose entry at the training index has its usefulness bit clear. The allocation writes the training tag, the result, counter 0 and usefulness 0. If no such table exists, nothing is allocated.
- R8: A correct training of a tagged provider sets that entry's usefulness bit when the alternative value would have been wrong. The alternative is the longest hitting shorter table, or the base table if no shorter table hits.
- R9: On every 2^U_CLR_LOG-th training since reset (256 by default), all usefulness bits are cleared after that training's own write.
- R10: When a request and a training address the same entry in the same cycle, the returned prediction shows the contents before the training.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_req | input | 1 | Lookup request |
| pred_pc | input | PC_W | Instruction address for the lookup |
| pred_hist | input | 64 | Global history for the lookup, bit 0 newest |
| pred_valid | output | 1 | Lookup result valid, one cycle after pred_req |
| pred_value | output | 64 | Predicted value |
| pred_use | output | 1 | Provider confidence saturated |
| pred_provider | output | PROV_W | Providing table, 0 = base, i = tagged table i |
| trn_valid | input | 1 | Training request |
| trn_pc | input | PC_W | Instruction address being trained |
| trn_hist | input | 64 | Global history used at prediction time |
| trn_result | input | 64 | Actual result |
| trn_provider | input | PROV_W | Provider reported for that prediction |

## Verification
Each training pattern is followed by lookups, and the lookups are chosen to tell the tables apart.

- **Same address, different history bits.** Flipping history bit 0 must fall back to the base table. Flipping bit 3 must leave table 1 visible but hide table 2. This shows that each table uses only its own history length.
- **Repeated correct results against a changed result.** These separate counter saturation from counter reset.
- **Request and training in the same cycle.** This shows that the lookup returns the contents before the write.
- **Wrong result after an entry has become useful.** Allocation must skip that entry. The same pattern repeated after the 256th training shows that the periodic clear frees the entry again.

// File: rtl/geovp_pkg.sv
package geovp_pkg;

  localparam int GHIST_W = 64;
  localparam int VALUE_W = 64;

  // history length seen by tagged component comp (1-based): 2, 4, 8, ... capped
  function automatic int hist_len(input int comp);
    int l;
    l = 1 << comp;
    if (l > GHIST_W) l = GHIST_W;
    return l;
  endfunction

  // fold the newest len history bits down to width bits by xor
  function automatic logic [31:0] fold_hist(input logic [GHIST_W-1:0] h,
                                            input int len, input int width);
    logic [31:0] acc;
    acc = '0;
    for (int b = 0; b < GHIST_W; b++) begin
      if (b < len) acc[b % width] = acc[b % width] ^ h[b];
    end
    return acc;
  endfunction

  function automatic logic [31:0] low_mask(input int width);
    return (32'd1 << width) - 32'd1;
  endfunction

  // address folded onto itself
  function automatic logic [31:0] mix_pc(input logic [63:0] pc, input int width);
    logic [63:0] sh;
    sh = pc >> width;
    return (pc[31:0] ^ sh[31:0]) & low_mask(width);
  endfunction

  function automatic logic [31:0] entry_index(input logic [63:0] pc,
                                              input logic [GHIST_W-1:0] h,
                                              input int len, input int width);
    return (mix_pc(pc, width) ^ fold_hist(h, len, width)) & low_mask(width);
  endfunction

  function automatic logic [31:0] entry_tag(input logic [63:0] pc,
                                            input logic [GHIST_W-1:0] h,
                                            input int len, input int width);
    logic [31:0] t;
    t = pc[33:2] ^ fold_hist(h, len, width) ^ (fold_hist(h, len, width - 1) << 1);
    return t & low_mask(width);
  endfunction

  // confidence step: saturating increment on correct, clear on wrong
  function automatic logic [7:0] conf_step(input logic [7:0] c, input logic ok,
                                           input int width);
    logic [7:0] top;
    top = 8'((1 << width) - 1);
    if (!ok) return 8'd0;
    if (c == top) return c;
    return c + 8'd1;
  endfunction

endpackage

// File: rtl/geovp_base_tbl.sv
module geovp_base_tbl import geovp_pkg::*; #(
  parameter int LOG_N  = 10,
  parameter int PC_W   = 48,
  parameter int CONF_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [PC_W-1:0]    rd_pc,
  output logic [VALUE_W-1:0] rd_value,
  output logic [CONF_W-1:0]  rd_ctr,
  input  logic [PC_W-1:0]    trn_pc,
  output logic [VALUE_W-1:0] trn_value,
  output logic [CONF_W-1:0]  trn_ctr,
  input  logic               wr_en,
  input  logic [VALUE_W-1:0] wr_value,
  input  logic [CONF_W-1:0]  wr_ctr
);
  localparam int N = 1 << LOG_N;

  logic [VALUE_W-1:0] value_q [N];
  logic [CONF_W-1:0]  ctr_q   [N];

  logic [LOG_N-1:0] rd_idx, trn_idx;
  assign rd_idx  = LOG_N'(mix_pc(64'(rd_pc), LOG_N));
  assign trn_idx = LOG_N'(mix_pc(64'(trn_pc), LOG_N));

  assign trn_value = value_q[trn_idx];
  assign trn_ctr   = ctr_q[trn_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) begin
        value_q[k] <= '0;
        ctr_q[k]   <= '0;
      end
    end else if (wr_en) begin
      value_q[trn_idx] <= wr_value;
      ctr_q[trn_idx]   <= wr_ctr;
    end
  end

  // registered read: sees contents before a same-cycle write (R10)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_value <= '0;
      rd_ctr   <= '0;
    end else if (rd_en) begin
      rd_value <= value_q[rd_idx];
      rd_ctr   <= ctr_q[rd_idx];
    end
  end

endmodule

// File: rtl/geovp_tag_bank.sv
module geovp_tag_bank import geovp_pkg::*; #(
  parameter int COMP   = 1,
  parameter int LOG_N  = 9,
  parameter int TAG_W  = 11,
  parameter int PC_W   = 48,
  parameter int CONF_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [PC_W-1:0]    rd_pc,
  input  logic [GHIST_W-1:0] rd_hist,
  output logic               rd_hit,
  output logic [VALUE_W-1:0] rd_value,
  output logic [CONF_W-1:0]  rd_ctr,
  input  logic [PC_W-1:0]    trn_pc,
  input  logic [GHIST_W-1:0] trn_hist,
  output logic               trn_hit,
  output logic [VALUE_W-1:0] trn_value,
  output logic [CONF_W-1:0]  trn_ctr,
  output logic               trn_u,
  input  logic               wr_en,
  input  logic [VALUE_W-1:0] wr_value,
  input  logic [CONF_W-1:0]  wr_ctr,
  input  logic               wr_u,
  input  logic               u_clear
);
  localparam int N   = 1 << LOG_N;
  localparam int LEN = hist_len(COMP);

  logic               valid_q [N];
  logic [TAG_W-1:0]   tag_q   [N];
  logic [VALUE_W-1:0] value_q [N];
  logic [CONF_W-1:0]  ctr_q   [N];
  logic               u_q     [N];

  logic [LOG_N-1:0] rd_idx, trn_idx;
  logic [TAG_W-1:0] rd_tag, trn_tag;
  assign rd_idx  = LOG_N'(entry_index(64'(rd_pc), rd_hist, LEN, LOG_N));
  assign rd_tag  = TAG_W'(entry_tag(64'(rd_pc), rd_hist, LEN, TAG_W));
  assign trn_idx = LOG_N'(entry_index(64'(trn_pc), trn_hist, LEN, LOG_N));
  assign trn_tag = TAG_W'(entry_tag(64'(trn_pc), trn_hist, LEN, TAG_W));

  assign trn_hit   = valid_q[trn_idx] && (tag_q[trn_idx] == trn_tag);
  assign trn_value = value_q[trn_idx];
  assign trn_ctr   = ctr_q[trn_idx];
  assign trn_u     = u_q[trn_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) begin
        valid_q[k] <= 1'b0;
        tag_q[k]   <= '0;
        value_q[k] <= '0;
        ctr_q[k]   <= '0;
        u_q[k]     <= 1'b0;
      end
    end else begin
      if (wr_en) begin
        valid_q[trn_idx] <= 1'b1;
        tag_q[trn_idx]   <= trn_tag;
        value_q[trn_idx] <= wr_value;
        ctr_q[trn_idx]   <= wr_ctr;
        u_q[trn_idx]     <= wr_u;
      end
      // periodic clear overrides this cycle's write of the bit (R9)
      if (u_clear) begin
        for (int k = 0; k < N; k++) u_q[k] <= 1'b0;
      end
    end
  end

  logic               rd_valid_r;
  logic [TAG_W-1:0]   rd_stored_r, rd_want_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_r  <= 1'b0;
      rd_stored_r <= '0;
      rd_want_r   <= '0;
      rd_value    <= '0;
      rd_ctr      <= '0;
    end else if (rd_en) begin
      rd_valid_r  <= valid_q[rd_idx];
      rd_stored_r <= tag_q[rd_idx];
      rd_want_r   <= rd_tag;
      rd_value    <= value_q[rd_idx];
      rd_ctr      <= ctr_q[rd_idx];
    end
  end

  assign rd_hit = rd_valid_r && (rd_stored_r == rd_want_r);

endmodule

// File: rtl/geovp_select.sv
module geovp_select import geovp_pkg::*; #(
  parameter int NT     = 6,
  parameter int CONF_W = 3,
  parameter int PROV_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NT-1:0]                 hit,
  input  logic [NT-1:0][VALUE_W-1:0]    values,
  input  logic [NT-1:0][CONF_W-1:0]     ctrs,
  input  logic [VALUE_W-1:0]            base_value,
  input  logic [CONF_W-1:0]             base_ctr,
  output logic [PROV_W-1:0]             sel_prov,
  output logic [VALUE_W-1:0]            sel_value,
  output logic [CONF_W-1:0]             sel_ctr
);
  // longest matching history wins; later iterations override earlier ones
  always_comb begin
    sel_prov  = '0;
    sel_value = base_value;
    sel_ctr   = base_ctr;
    for (int i = 0; i < NT; i++) begin
      if (hit[i]) begin
        sel_prov  = PROV_W'(i + 1);
        sel_value = values[i];
        sel_ctr   = ctrs[i];
      end
    end
  end

  for (genvar g = 0; g < NT; g++) begin : g_chk
    // R3: no hitting table is longer than the chosen provider
    p_no_longer_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] |-> (sel_prov >= PROV_W'(g + 1)));
    // R3: the chosen provider actually hits
    p_provider_hits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_prov == PROV_W'(g + 1)) |-> hit[g]);
  end

endmodule

// File: rtl/geo_value_predictor.sv
module geo_value_predictor import geovp_pkg::*; #(
  parameter int PC_W       = 48,
  parameter int NUM_TAGGED = 6,
  parameter int LOG_BASE   = 10,
  parameter int LOG_TAGGED = 9,
  parameter int TAG_W      = 11,
  parameter int CONF_W     = 3,
  parameter int U_CLR_LOG  = 8,
  localparam int PROV_W    = $clog2(NUM_TAGGED + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pred_req,
  input  logic [PC_W-1:0]    pred_pc,
  input  logic [GHIST_W-1:0] pred_hist,
  output logic               pred_valid,
  output logic [VALUE_W-1:0] pred_value,
  output logic               pred_use,
  output logic [PROV_W-1:0]  pred_provider,
  input  logic               trn_valid,
  input  logic [PC_W-1:0]    trn_pc,
  input  logic [GHIST_W-1:0] trn_hist,
  input  logic [VALUE_W-1:0] trn_result,
  input  logic [PROV_W-1:0]  trn_provider
);
  localparam logic [CONF_W-1:0] CONF_MAX = CONF_W'((1 << CONF_W) - 1);

  // lookup side
  logic [NUM_TAGGED-1:0]               rd_hit;
  logic [NUM_TAGGED-1:0][VALUE_W-1:0]  rd_val;
  logic [NUM_TAGGED-1:0][CONF_W-1:0]   rd_ctr;
  logic [VALUE_W-1:0]                  base_rd_value;
  logic [CONF_W-1:0]                   base_rd_ctr;
  logic [CONF_W-1:0]                   sel_ctr;
  logic                                pred_valid_q;

  // training side
  logic [NUM_TAGGED-1:0]               trn_hit;
  logic [NUM_TAGGED-1:0][VALUE_W-1:0]  trn_val;
  logic [NUM_TAGGED-1:0][CONF_W-1:0]   trn_ctr;
  logic [NUM_TAGGED-1:0]               trn_u;
  logic [VALUE_W-1:0]                  base_trn_value;
  logic [CONF_W-1:0]                   base_trn_ctr;

  logic [VALUE_W-1:0] prov_value, alt_value;
  logic [CONF_W-1:0]  prov_ctr, next_ctr;
  logic               trn_correct;
  logic               useful_set;
  logic [NUM_TAGGED-1:0] alloc_vec;
  logic               alloc_found, alloc_en;
  logic [U_CLR_LOG-1:0] trn_count;
  logic               u_clear;

  geovp_base_tbl #(.LOG_N(LOG_BASE), .PC_W(PC_W), .CONF_W(CONF_W)) u_base (
    .clk(clk), .rst_n(rst_n),
    .rd_en(pred_req), .rd_pc(pred_pc), .rd_value(base_rd_value), .rd_ctr(base_rd_ctr),
    .trn_pc(trn_pc), .trn_value(base_trn_value), .trn_ctr(base_trn_ctr),
    .wr_en(trn_valid && (trn_provider == '0)),
    .wr_value(trn_result), .wr_ctr(next_ctr)
  );

  for (genvar g = 0; g < NUM_TAGGED; g++) begin : g_bank
    logic               is_prov;
    logic               wr_en;
    logic [CONF_W-1:0]  wr_ctr;
    logic               wr_u;
    assign is_prov = (trn_provider == PROV_W'(g + 1));
    assign wr_en   = trn_valid && (is_prov || (alloc_en && alloc_vec[g]));
    assign wr_ctr  = is_prov ? next_ctr : '0;
    assign wr_u    = is_prov ? (trn_u[g] | useful_set) : 1'b0;

    geovp_tag_bank #(.COMP(g + 1), .LOG_N(LOG_TAGGED), .TAG_W(TAG_W),
                     .PC_W(PC_W), .CONF_W(CONF_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .rd_en(pred_req), .rd_pc(pred_pc), .rd_hist(pred_hist),
      .rd_hit(rd_hit[g]), .rd_value(rd_val[g]), .rd_ctr(rd_ctr[g]),
      .trn_pc(trn_pc), .trn_hist(trn_hist),
      .trn_hit(trn_hit[g]), .trn_value(trn_val[g]), .trn_ctr(trn_ctr[g]), .trn_u(trn_u[g]),
      .wr_en(wr_en), .wr_value(trn_result), .wr_ctr(wr_ctr), .wr_u(wr_u),
      .u_clear(u_clear)
    );
  end

  geovp_select #(.NT(NUM_TAGGED), .CONF_W(CONF_W), .PROV_W(PROV_W)) u_sel (
    .clk(clk), .rst_n(rst_n),
    .hit(rd_hit), .values(rd_val), .ctrs(rd_ctr),
    .base_value(base_rd_value), .base_ctr(base_rd_ctr),
    .sel_prov(pred_provider), .sel_value(pred_value), .sel_ctr(sel_ctr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pred_valid_q <= 1'b0;
    else        pred_valid_q <= pred_req;
  end

  assign pred_valid = pred_valid_q;
  assign pred_use   = pred_valid_q && (sel_ctr == CONF_MAX);

  // provider entry as it stands at training time
  always_comb begin
    prov_value = base_trn_value;
    prov_ctr   = base_trn_ctr;
    for (int i = 0; i < NUM_TAGGED; i++) begin
      if (trn_provider == PROV_W'(i + 1)) begin
        prov_value = trn_val[i];
        prov_ctr   = trn_ctr[i];
      end
    end
  end

  assign trn_correct = (prov_value == trn_result);
  assign next_ctr    = CONF_W'(conf_step(8'(prov_ctr), trn_correct, CONF_W));

  // alternative: longest hit strictly below the provider, else base
  always_comb begin
    alt_value = base_trn_value;
    for (int i = 0; i < NUM_TAGGED; i++) begin
      if (trn_hit[i] && (PROV_W'(i + 1) < trn_provider)) alt_value = trn_val[i];
    end
  end

  assign useful_set = trn_valid && (trn_provider != '0) && trn_correct &&
                      (alt_value != trn_result);

  // allocation target: first longer table whose entry is not useful
  always_comb begin
    alloc_vec   = '0;
    alloc_found = 1'b0;
    for (int j = 0; j < NUM_TAGGED; j++) begin
      if (!alloc_found && (PROV_W'(j + 1) > trn_provider) && !trn_u[j]) begin
        alloc_vec[j] = 1'b1;
        alloc_found  = 1'b1;
      end
    end
  end

  assign alloc_en = trn_valid && !trn_correct && alloc_found;

  always_ff @(posedge clk) begin
    if (!rst_n)         trn_count <= '0;
    else if (trn_valid) trn_count <= trn_count + 1'b1;
  end

  assign u_clear = trn_valid && (&trn_count);

  // R7: at most one table receives an allocation
  p_alloc_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_vec));
  // R7: allocation never overwrites a useful entry
  p_alloc_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> ((alloc_vec & trn_u) == '0));
  // R8: usefulness is only granted on a correct guess, never together with allocation
  p_useful_no_alloc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    useful_set |-> !alloc_en);
  // R9: a clear coincides with the training counter wrapping to zero
  p_clear_wraps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    u_clear |=> (trn_count == '0));

endmodule

// File: tb/tb_geo_value_predictor.sv
`timescale 1ns/1ps
module tb_geo_value_predictor;
  localparam int PROV_W = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pred_req = 1'b0;
  logic [47:0] pred_pc = '0;
  logic [63:0] pred_hist = '0;
  logic        pred_valid;
  logic [63:0] pred_value;
  logic        pred_use;
  logic [PROV_W-1:0] pred_provider;
  logic        trn_valid = 1'b0;
  logic [47:0] trn_pc = '0;
  logic [63:0] trn_hist = '0;
  logic [63:0] trn_result = '0;
  logic [PROV_W-1:0] trn_provider = '0;

  int checks = 0;
  int fails  = 0;

  geo_value_predictor dut (
    .clk(clk), .rst_n(rst_n),
    .pred_req(pred_req), .pred_pc(pred_pc), .pred_hist(pred_hist),
    .pred_valid(pred_valid), .pred_value(pred_value), .pred_use(pred_use),
    .pred_provider(pred_provider),
    .trn_valid(trn_valid), .trn_pc(trn_pc), .trn_hist(trn_hist),
    .trn_result(trn_result), .trn_provider(trn_provider)
  );

  always #10 clk = ~clk;

  localparam logic [47:0] P  = 48'h0000_1234_5670;
  localparam logic [47:0] Q  = P ^ 48'h1;
  localparam logic [63:0] H  = 64'hA5A5_0000_F0F0_1230;
  localparam logic [63:0] HB = H ^ 64'h1;
  localparam logic [63:0] HS = H ^ 64'h8;
  localparam logic [63:0] X  = 64'h1111_2222_3333_4444;
  localparam logic [63:0] Y  = 64'hDEAD_BEEF_0000_0007;
  localparam logic [63:0] Z  = 64'h0F0F_0F0F_0F0F_0F0F;
  localparam logic [63:0] W  = 64'h7777_0000_7777_0000;
  localparam logic [63:0] K  = 64'h0000_0000_0000_00AA;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic chk_pred(input string req, input logic [63:0] v, input logic u,
                          input logic [PROV_W-1:0] p);
    chk({req, " valid"},    64'(pred_valid),    64'd1);
    chk({req, " value"},    pred_value,         v);
    chk({req, " use"},      64'(pred_use),      64'(u));
    chk({req, " provider"}, 64'(pred_provider), 64'(p));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // request at one negedge; result is registered at the next posedge
  task automatic predict(input logic [47:0] pc, input logic [63:0] h);
    @(negedge clk);
    pred_req = 1'b1; pred_pc = pc; pred_hist = h;
    @(negedge clk);
    pred_req = 1'b0;
  endtask

  task automatic train(input logic [47:0] pc, input logic [63:0] h,
                       input logic [63:0] res, input logic [PROV_W-1:0] p);
    @(negedge clk);
    trn_valid = 1'b1; trn_pc = pc; trn_hist = h; trn_result = res; trn_provider = p;
    @(negedge clk);
    trn_valid = 1'b0;
  endtask

  task automatic train_and_predict(input logic [47:0] pc, input logic [63:0] h,
                                   input logic [63:0] res, input logic [PROV_W-1:0] p);
    @(negedge clk);
    trn_valid = 1'b1; trn_pc = pc; trn_hist = h; trn_result = res; trn_provider = p;
    pred_req = 1'b1; pred_pc = pc; pred_hist = h;
    @(negedge clk);
    trn_valid = 1'b0;
    pred_req  = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    predict(P, H);
    chk_pred("R1 empty lookup", 64'd0, 1'b0, 3'd0);
    @(negedge clk);
    chk("R1 valid drops without request", 64'(pred_valid), 64'd0);
  endtask

  task automatic t_learn();
    do_reset();
    train(P, H, X, 3'd0);                 // base wrong: base=X, table 1 allocated
    predict(P, H);
    chk_pred("R7 first allocation in table 1", X, 1'b0, 3'd1);
    predict(P, HB);                       // bit 0 moves every tagged entry
    chk_pred("R2 R4 fallback to base", X, 1'b0, 3'd0);
    for (int n = 0; n < 6; n++) train(P, H, X, 3'd1);
    predict(P, H);
    chk_pred("R5 counter at 6 not usable", X, 1'b0, 3'd1);
    train(P, H, X, 3'd1);
    predict(P, H);
    chk_pred("R5 counter saturated", X, 1'b1, 3'd1);
    train(P, H, X, 3'd1);
    predict(P, H);
    chk_pred("R5 stays saturated", X, 1'b1, 3'd1);
    train_and_predict(P, H, Y, 3'd1);     // wrong; lookup in same cycle
    chk_pred("R10 same-cycle old contents", X, 1'b1, 3'd1);
    predict(P, H);
    chk_pred("R3 longer table 2 wins", Y, 1'b0, 3'd2);
    predict(P, HS);                       // bit 3 hides table 2 only
    chk_pred("R6 R4 table 1 reset and replaced", Y, 1'b0, 3'd1);
  endtask

  task automatic t_useful_and_clear();
    do_reset();
    train(P, H, X, 3'd0);                 // 1: base=X, t1=X
    train(P, H, Y, 3'd1);                 // 2: t1=Y, t2=Y
    train(P, H, Y, 3'd1);                 // 3: correct, base X wrong -> t1 useful
    train(P, H, Z, 3'd0);                 // 4: base wrong, t1 skipped, t2=Z
    predict(P, H);
    chk_pred("R7 allocation into table 2", Z, 1'b0, 3'd2);
    predict(P, HS);
    chk_pred("R8 useful table 1 kept", Y, 1'b0, 3'd1);
    for (int n = 0; n < 252; n++) train(Q, H, K, 3'd0);  // trainings 5..256
    train(P, H, W, 3'd0);                 // 257: t1 free again -> t1=W
    predict(P, HS);
    chk_pred("R9 usefulness cleared at rollover", W, 1'b0, 3'd1);
    predict(Q, H ^ 64'h8);
    chk_pred("R2 other address untouched", K, 1'b0, 3'd1);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_learn();
    t_useful_and_clear();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule